// File: doc/BRIEF.md
# Integer Add/Subtract/Compare Unit

This block is the add, subtract and compare slice of a 64-bit integer execute stage. Each cycle it takes operand A, an operand B and a 7-bit function code. Operand B is either a register value or an 8-bit literal widened with zeros. One clock edge later it presents a 64-bit result, an overflow-trap flag and an illegal-function flag.

The arithmetic works on 32-bit or 64-bit data. A can be pre-scaled by 4 or 8 before the add or subtract. The trapping forms report signed overflow, and the wrapped result is still delivered with the flag. Results of 32-bit operations are sign-extended from bit 31.

The compare forms return 0 or 1 for equality, signed ordering and unsigned ordering. A byte-parallel form returns an 8-bit mask of unsigned per-byte greater-or-equal results.

Top module: `int_arith_unit`

## Requirements
- R1: When `b_is_lit` is 1, operand B is `lit_val` with zeros above bit 7, and `opb` has no effect. When `b_is_lit` is 0, operand B is `opb`.
- R2: Code 0x20 gives A+B and code 0x29 gives A-B, both modulo 2^64.
- R3: Code 0x00 (add) and code 0x09 (subtract) use only bits 31:0 of A and B. Bit 31 of the 32-bit result is copied into bits 63:32.
- R4: The scaled codes shift A left before the operation. Codes 0x02 and 0x0b (32-bit add and subtract) and codes 0x22 and 0x2b (64-bit) shift by 2. Codes 0x12, 0x1b, 0x32 and 0x3b shift by 3. A 32-bit scaled result is sign-extended from bit 31.
- R5: Codes 0x40 (32-bit) and 0x60 (64-bit) add. They raise `ovf_trap` when the sign bits of A and B are equal and the result sign bit differs from that of A.
- R6: Codes 0x49 (32-bit) and 0x69 (64-bit) subtract. They raise `ovf_trap` when the sign bits of A and B differ and the result sign bit differs from that of A.
- R7: When `ovf_trap` is raised, `result` still carries the wrapped value. Codes without trap never raise `ovf_trap`, even when their result overflows.
- R8: The compare codes return 1 when their condition holds and 0 otherwise: 0x2d equal, 0x4d signed less-than, 0x6d signed less-or-equal, 0x1d unsigned less-than, 0x3d unsigned less-or-equal.
- R9: Code 0x0f sets result bit i when byte i of A is at least byte i of B, comparing unsigned. Bits 63:8 are zero.
- R10: Any other code gives `illegal_op`=1, `result`=0 and `ovf_trap`=0.
- R11: Outputs change one clock edge after the inputs. While `rst_n` is low, `result`, `ovf_trap` and `illegal_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 64 | Operand A |
| opb | input | 64 | Register operand B |
| b_is_lit | input | 1 | Selects the literal as operand B |
| lit_val | input | 8 | Literal operand |
| func | input | 7 | Function code |
| result | output | 64 | Registered result |
| ovf_trap | output | 1 | Signed overflow on a trapping code |
| illegal_op | output | 1 | Function code not recognised |

## Verification
The bench targets the sign boundaries of both widths. Cases include 0x7FFF_FFFF+1 in the trapping 32-bit add, 0x8000_0000-1 in the trapping 32-bit subtract, and the 64-bit equivalents, with matching same-sign and opposite-sign pairs that must not trap. A design that took the sign from the wrong bit, or swapped the add and subtract sign rules, would flag the wrong vector. A design that cleared the result on a trap would lose the wrapped value.

The scaled vectors push A's top bits out of range, so shifting after the add or sign-extending before the shift gives a different value. The compare vectors separate signed from unsigned ordering with 0x8000.. against 0x7FFF.. and all-ones against zero. The byte mask vector mixes equal, greater and smaller bytes, so a swapped bit order or a signed byte compare shows up at once.

// File: rtl/iacu_pkg.sv
package iacu_pkg;

  typedef enum logic [2:0] {
    K_ARITH  = 3'd0,
    K_EQ     = 3'd1,
    K_SLT    = 3'd2,
    K_SLE    = 3'd3,
    K_ULT    = 3'd4,
    K_ULE    = 3'd5,
    K_BYTEGE = 3'd6,
    K_NONE   = 3'd7
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       sub;
    logic       wide;
    logic [1:0] shamt;
    logic       trap;
  } ctl_t;

  // Function codes (7 bits)
  localparam logic [6:0] FN_ADD32    = 7'h00;
  localparam logic [6:0] FN_ADD32T   = 7'h40;
  localparam logic [6:0] FN_ADD32S4  = 7'h02;
  localparam logic [6:0] FN_ADD32S8  = 7'h12;
  localparam logic [6:0] FN_ADD64    = 7'h20;
  localparam logic [6:0] FN_ADD64T   = 7'h60;
  localparam logic [6:0] FN_ADD64S4  = 7'h22;
  localparam logic [6:0] FN_ADD64S8  = 7'h32;
  localparam logic [6:0] FN_SUB32    = 7'h09;
  localparam logic [6:0] FN_SUB32T   = 7'h49;
  localparam logic [6:0] FN_SUB32S4  = 7'h0b;
  localparam logic [6:0] FN_SUB32S8  = 7'h1b;
  localparam logic [6:0] FN_SUB64    = 7'h29;
  localparam logic [6:0] FN_SUB64T   = 7'h69;
  localparam logic [6:0] FN_SUB64S4  = 7'h2b;
  localparam logic [6:0] FN_SUB64S8  = 7'h3b;
  localparam logic [6:0] FN_CMPEQ    = 7'h2d;
  localparam logic [6:0] FN_CMPSLE   = 7'h6d;
  localparam logic [6:0] FN_CMPSLT   = 7'h4d;
  localparam logic [6:0] FN_CMPULE   = 7'h3d;
  localparam logic [6:0] FN_CMPULT   = 7'h1d;
  localparam logic [6:0] FN_BYTEGE   = 7'h0f;

  function automatic ctl_t mk_arith(input logic sub, input logic wide,
                                    input logic [1:0] shamt, input logic trap);
    ctl_t c;
    c.kind  = K_ARITH;
    c.sub   = sub;
    c.wide  = wide;
    c.shamt = shamt;
    c.trap  = trap;
    return c;
  endfunction

  function automatic ctl_t mk_other(input kind_e k);
    ctl_t c;
    c.kind  = k;
    c.sub   = 1'b0;
    c.wide  = 1'b1;
    c.shamt = 2'd0;
    c.trap  = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/iacu_decode.sv
module iacu_decode
  import iacu_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] func,
  output ctl_t              ctl
);

  always_comb begin
    case (func)
      FN_ADD32:   ctl = mk_arith(1'b0, 1'b0, 2'd0, 1'b0);
      FN_ADD32T:  ctl = mk_arith(1'b0, 1'b0, 2'd0, 1'b1);
      FN_ADD32S4: ctl = mk_arith(1'b0, 1'b0, 2'd2, 1'b0);
      FN_ADD32S8: ctl = mk_arith(1'b0, 1'b0, 2'd3, 1'b0);
      FN_ADD64:   ctl = mk_arith(1'b0, 1'b1, 2'd0, 1'b0);
      FN_ADD64T:  ctl = mk_arith(1'b0, 1'b1, 2'd0, 1'b1);
      FN_ADD64S4: ctl = mk_arith(1'b0, 1'b1, 2'd2, 1'b0);
      FN_ADD64S8: ctl = mk_arith(1'b0, 1'b1, 2'd3, 1'b0);
      FN_SUB32:   ctl = mk_arith(1'b1, 1'b0, 2'd0, 1'b0);
      FN_SUB32T:  ctl = mk_arith(1'b1, 1'b0, 2'd0, 1'b1);
      FN_SUB32S4: ctl = mk_arith(1'b1, 1'b0, 2'd2, 1'b0);
      FN_SUB32S8: ctl = mk_arith(1'b1, 1'b0, 2'd3, 1'b0);
      FN_SUB64:   ctl = mk_arith(1'b1, 1'b1, 2'd0, 1'b0);
      FN_SUB64T:  ctl = mk_arith(1'b1, 1'b1, 2'd0, 1'b1);
      FN_SUB64S4: ctl = mk_arith(1'b1, 1'b1, 2'd2, 1'b0);
      FN_SUB64S8: ctl = mk_arith(1'b1, 1'b1, 2'd3, 1'b0);
      FN_CMPEQ:   ctl = mk_other(K_EQ);
      FN_CMPSLE:  ctl = mk_other(K_SLE);
      FN_CMPSLT:  ctl = mk_other(K_SLT);
      FN_CMPULE:  ctl = mk_other(K_ULE);
      FN_CMPULT:  ctl = mk_other(K_ULT);
      FN_BYTEGE:  ctl = mk_other(K_BYTEGE);
      default:    ctl = mk_other(K_NONE);
    endcase
  end

endmodule

// File: rtl/iacu_addsub.sv
module iacu_addsub #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              wide,
  input  logic [1:0]        shamt,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_raw
);

  localparam int EXT_W = DATA_W - HALF_W;

  function automatic logic [DATA_W-1:0] f_scale(input logic [DATA_W-1:0] v,
                                                input logic [1:0] s);
    return v << s;
  endfunction

  function automatic logic [DATA_W-1:0] f_sext_half(input logic [DATA_W-1:0] v);
    return {{EXT_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  logic [DATA_W-1:0] a_s;
  logic [DATA_W-1:0] raw;
  logic              sgn_a, sgn_b, sgn_r;

  assign a_s   = f_scale(a, shamt);
  assign raw   = sub ? (a_s - b) : (a_s + b);
  assign sum   = wide ? raw : f_sext_half(raw);
  assign sgn_a = wide ? a_s[DATA_W-1] : a_s[HALF_W-1];
  assign sgn_b = wide ? b[DATA_W-1]   : b[HALF_W-1];
  assign sgn_r = wide ? raw[DATA_W-1] : raw[HALF_W-1];
  assign ovf_raw = sub ? ((sgn_a != sgn_b) && (sgn_r != sgn_a))
                       : ((sgn_a == sgn_b) && (sgn_r != sgn_a));

  // One-bit-wider results, used only as an independent overflow reference
  logic [DATA_W:0] ext_w;
  logic [HALF_W:0] ext_h;
  assign ext_w = sub ? ({a_s[DATA_W-1], a_s} - {b[DATA_W-1], b})
                     : ({a_s[DATA_W-1], a_s} + {b[DATA_W-1], b});
  assign ext_h = sub ? ({a_s[HALF_W-1], a_s[HALF_W-1:0]} - {b[HALF_W-1], b[HALF_W-1:0]})
                     : ({a_s[HALF_W-1], a_s[HALF_W-1:0]} + {b[HALF_W-1], b[HALF_W-1:0]});

  AST_ADD_OVF_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !sub) |-> (ovf_raw == (ext_w[DATA_W] != ext_w[DATA_W-1]))); // R5
  AST_ADD_OVF_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !sub) |-> (ovf_raw == (ext_h[HALF_W] != ext_h[HALF_W-1]))); // R5
  AST_SUB_OVF_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && sub) |-> (ovf_raw == (ext_w[DATA_W] != ext_w[DATA_W-1]))); // R6
  AST_SUB_OVF_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && sub) |-> (ovf_raw == (ext_h[HALF_W] != ext_h[HALF_W-1]))); // R6

endmodule

// File: rtl/iacu_cmp.sv
module iacu_cmp #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              eq,
  output logic              slt,
  output logic              sle,
  output logic              ult,
  output logic              ule,
  output logic [DATA_W/BYTE_W-1:0] byte_ge
);

  localparam int NBYTES = DATA_W / BYTE_W;

  function automatic logic f_slt(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  assign eq  = (a == b);
  assign ult = (a < b);
  assign ule = ult | eq;
  assign slt = f_slt(a, b);
  assign sle = slt | eq;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign byte_ge[i] = (a[i*BYTE_W +: BYTE_W] >= b[i*BYTE_W +: BYTE_W]);
  end

  AST_EQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    eq |-> (sle && ule && !slt && !ult)); // R8
  AST_SIGN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (a[DATA_W-1] != b[DATA_W-1]) |-> (slt != ult)); // R8
  AST_EQ_ALL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    eq |-> (&byte_ge)); // R9

endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
  import iacu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8,
  parameter int FUNC_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              b_is_lit,
  input  logic [LIT_W-1:0]  lit_val,
  input  logic [FUNC_W-1:0] func,
  output logic [DATA_W-1:0] result,
  output logic              ovf_trap,
  output logic              illegal_op
);

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;
  localparam int NBYTES = DATA_W / BYTE_W;

  ctl_t              ctl, ctl_q;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic              ovf_raw;
  logic              c_eq, c_slt, c_sle, c_ult, c_ule;
  logic [NBYTES-1:0] c_byte;
  logic [DATA_W-1:0] res_d;
  logic              ovf_d, ill_d;

  assign b_eff = b_is_lit ? {{(DATA_W-LIT_W){1'b0}}, lit_val} : opb;

  iacu_decode #(.FUNC_W(FUNC_W)) u_dec (.func(func), .ctl(ctl));

  iacu_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_as (
    .clk(clk), .rst_n(rst_n), .a(opa), .b(b_eff),
    .sub(ctl.sub), .wide(ctl.wide), .shamt(ctl.shamt),
    .sum(sum), .ovf_raw(ovf_raw)
  );

  iacu_cmp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .a(opa), .b(b_eff),
    .eq(c_eq), .slt(c_slt), .sle(c_sle), .ult(c_ult), .ule(c_ule),
    .byte_ge(c_byte)
  );

  function automatic logic [DATA_W-1:0] f_bool(input logic v);
    return {{(DATA_W-1){1'b0}}, v};
  endfunction

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    ill_d = 1'b0;
    case (ctl.kind)
      K_ARITH: begin
        res_d = sum;
        ovf_d = ctl.trap & ovf_raw;
      end
      K_EQ:     res_d = f_bool(c_eq);
      K_SLT:    res_d = f_bool(c_slt);
      K_SLE:    res_d = f_bool(c_sle);
      K_ULT:    res_d = f_bool(c_ult);
      K_ULE:    res_d = f_bool(c_ule);
      K_BYTEGE: res_d = {{(DATA_W-NBYTES){1'b0}}, c_byte};
      default:  ill_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      ovf_trap   <= 1'b0;
      illegal_op <= 1'b0;
      ctl_q      <= mk_other(K_NONE);
    end else begin
      result     <= res_d;
      ovf_trap   <= ovf_d;
      illegal_op <= ill_d;
      ctl_q      <= ctl;
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (result == '0 && !ovf_trap)); // R10
  AST_TRAP_ONLY_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (ctl_q.kind == K_ARITH && ctl_q.trap)); // R7
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.kind inside {K_EQ, K_SLT, K_SLE, K_ULT, K_ULE}) |-> (result[DATA_W-1:1] == '0)); // R8
  AST_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.kind == K_BYTEGE) |-> (result[DATA_W-1:NBYTES] == '0)); // R9
  AST_SEXT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.kind == K_ARITH && !ctl_q.wide) |->
      (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}})); // R3

endmodule

// File: tb/sim_int_arith_unit.sv
`timescale 1ns/1ps
module sim_int_arith_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        b_is_lit = 1'b0;
  logic [7:0]  lit_val = '0;
  logic [6:0]  func = '0;
  logic [63:0] result;
  logic        ovf_trap, illegal_op;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  int_arith_unit u0 (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .b_is_lit(b_is_lit),
    .lit_val(lit_val), .func(func), .result(result),
    .ovf_trap(ovf_trap), .illegal_op(illegal_op)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [6:0]  fn;
    logic [63:0] a;
    logic [63:0] b;
    logic        ls;
    logic [7:0]  lit;
    logic [63:0] exp;
    logic        eo;
    logic        ei;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 8'h00, 64'h8000_0000_0000_0000, 1'b0, 1'b0}, // R2
    '{8'd2,  7'h29, 64'h0, 64'h1, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                   // R2
    '{8'd3,  7'h00, 64'hFFFF_FFFF_7FFF_FFFF, 64'h1, 1'b0, 8'h00, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0}, // R3
    '{8'd3,  7'h09, 64'h1234_5678_0000_0005, 64'hABCD_0000_0000_0003, 1'b0, 8'h00, 64'h2, 1'b0, 1'b0}, // R3
    '{8'd4,  7'h02, 64'h2000_0000, 64'h1, 1'b0, 8'h00, 64'hFFFF_FFFF_8000_0001, 1'b0, 1'b0},           // R4
    '{8'd4,  7'h12, 64'h3, 64'hFFFF, 1'b1, 8'h05, 64'h1D, 1'b0, 1'b0},                                  // R4 R1
    '{8'd4,  7'h22, 64'h1000_0000_0000_0000, 64'h7, 1'b0, 8'h00, 64'h4000_0000_0000_0007, 1'b0, 1'b0}, // R4
    '{8'd4,  7'h32, 64'h2000_0000_0000_0001, 64'h10, 1'b0, 8'h00, 64'h18, 1'b0, 1'b0},                 // R4
    '{8'd4,  7'h0b, 64'h1, 64'h8, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b0},                   // R4
    '{8'd4,  7'h1b, 64'h1000_0000, 64'h0, 1'b0, 8'h00, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0},           // R4
    '{8'd4,  7'h2b, 64'h5, 64'h0, 1'b1, 8'h14, 64'h0, 1'b0, 1'b0},                                      // R4
    '{8'd4,  7'h3b, 64'h2, 64'd20, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b0},                  // R4
    '{8'd5,  7'h40, 64'h7FFF_FFFF, 64'h1, 1'b0, 8'h00, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0},           // R5 R7
    '{8'd5,  7'h40, 64'hFFFF_FFFF, 64'h1, 1'b0, 8'h00, 64'h0, 1'b0, 1'b0},                             // R5
    '{8'd5,  7'h60, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 8'h00, 64'h0, 1'b1, 1'b0}, // R5
    '{8'd5,  7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'h00, 64'h7FFF_FFFF_FFFF_FFFE, 1'b0, 1'b0}, // R5
    '{8'd6,  7'h49, 64'h8000_0000, 64'h1, 1'b0, 8'h00, 64'h7FFF_FFFF, 1'b1, 1'b0},                     // R6 R7
    '{8'd6,  7'h49, 64'h8000_0000, 64'h8000_0000, 1'b0, 8'h00, 64'h0, 1'b0, 1'b0},                     // R6
    '{8'd6,  7'h69, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'h00, 64'h8000_0000_0000_0000, 1'b1, 1'b0}, // R6
    '{8'd6,  7'h69, 64'h0, 64'h1, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                   // R6
    '{8'd7,  7'h20, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 8'h00, 64'h0, 1'b0, 1'b0}, // R7
    '{8'd8,  7'h2d, 64'hDEAD, 64'hDEAD, 1'b0, 8'h00, 64'h1, 1'b0, 1'b0},                               // R8
    '{8'd8,  7'h2d, 64'h1, 64'h2, 1'b0, 8'h00, 64'h0, 1'b0, 1'b0},                                     // R8
    '{8'd8,  7'h6d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 8'h00, 64'h1, 1'b0, 1'b0},                   // R8
    '{8'd8,  7'h6d, 64'h5, 64'h5, 1'b0, 8'h00, 64'h1, 1'b0, 1'b0},                                     // R8
    '{8'd8,  7'h4d, 64'h5, 64'h5, 1'b0, 8'h00, 64'h0, 1'b0, 1'b0},                                     // R8
    '{8'd8,  7'h4d, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 8'h00, 64'h1, 1'b0, 1'b0}, // R8
    '{8'd8,  7'h3d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 8'h00, 64'h0, 1'b0, 1'b0},                   // R8
    '{8'd8,  7'h3d, 64'h3, 64'h3, 1'b0, 8'h00, 64'h1, 1'b0, 1'b0},                                     // R8
    '{8'd8,  7'h1d, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'h00, 64'h1, 1'b0, 1'b0},                   // R8
    '{8'd8,  7'h1d, 64'h3, 64'h3, 1'b0, 8'h00, 64'h0, 1'b0, 1'b0},                                     // R8
    '{8'd9,  7'h0f, 64'h00FF_1080_7F00_0102, 64'h0100_1080_8000_0201, 1'b0, 8'h00, 64'h75, 1'b0, 1'b0}, // R9
    '{8'd9,  7'h0f, 64'h4, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'h05, 64'hFE, 1'b0, 1'b0},                  // R9 R1
    '{8'd10, 7'h7F, 64'h1, 64'h1, 1'b0, 8'h00, 64'h0, 1'b0, 1'b1},                                     // R10
    '{8'd10, 7'h01, 64'hFFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 8'h00, 64'h0, 1'b0, 1'b1},                // R10
    '{8'd1,  7'h20, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'hFF, 64'h100, 1'b0, 1'b0}                  // R1
  };

  task automatic chk(input int req, input logic [63:0] er, input logic eo, input logic ei);
    n_chk++;
    if (result !== er || ovf_trap !== eo || illegal_op !== ei) begin
      n_bad++;
      $display("FAIL R%0d: got result=%h ovf=%b ill=%b, expected result=%h ovf=%b ill=%b",
               req, result, ovf_trap, illegal_op, er, eo, ei);
    end
  endtask

  task automatic drive(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                       input logic ls, input logic [7:0] l);
    func = f; opa = a; opb = b; b_is_lit = ls; lit_val = l;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11: outputs held at zero during reset even with live inputs
    @(negedge clk);
    drive(7'h20, 64'h5, 64'h6, 1'b0, 8'h0);
    @(negedge clk);
    chk(11, 64'h0, 1'b0, 1'b0);
    drive(7'h7F, 64'h5, 64'h6, 1'b0, 8'h0);
    @(negedge clk);
    chk(11, 64'h0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // Table walk: drive at a falling edge, check at the next falling edge
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].fn, VECS[i].a, VECS[i].b, VECS[i].ls, VECS[i].lit);
      @(negedge clk);
      chk(int'(VECS[i].req), VECS[i].exp, VECS[i].eo, VECS[i].ei);
    end

    // R11: one-edge latency
    drive(7'h20, 64'h5, 64'h6, 1'b0, 8'h0);
    @(negedge clk);
    chk(11, 64'hB, 1'b0, 1'b0);
    drive(7'h20, 64'h1, 64'h1, 1'b0, 8'h0);
    #1;
    chk(11, 64'hB, 1'b0, 1'b0);
    @(negedge clk);
    chk(11, 64'h2, 1'b0, 1'b0);

    // R7: trap flag clears on the next non-trapping op
    drive(7'h60, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'h0);
    @(negedge clk);
    chk(7, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    drive(7'h29, 64'h8000_0000_0000_0000, 64'h1, 1'b0, 8'h0);
    @(negedge clk);
    chk(7, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);

    // R11: reset mid-run clears outputs
    drive(7'h7F, 64'h0, 64'h0, 1'b0, 8'h0);
    @(negedge clk);
    chk(10, 64'h0, 1'b0, 1'b1);
    rst_n = 1'b0;
    #1;
    chk(11, 64'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule